// File: doc/BRIEF.md
# TDM Command and Audio Frame Deserializer

This block sits at the receive side of a time-division multiplexed serial link in which one frame per sample period carries a command packet followed by audio channel packets. It runs on the bit clock, detects the frame boundary from a frame-sync line, cuts the serial stream into 32-bit packets sent most significant bit first, and hands out only the traffic meant for this device: command fields addressed to its own ID, and the 24-bit samples of the channel slots that belong to it.

The device ID is not strapped. During the first bit clocks of a frame a single-cycle token travels down a chain of devices; each device that holds no ID yet takes its ID from the bit position at which the token reaches it and passes the token on, so neighbours receive consecutive IDs two bit clocks apart. The channel slots a device owns follow from its ID: device `d` owns channels `(d-1)*OWN_CH+1` to `d*OWN_CH`, counted from the first audio packet of the frame.

Top module: `tdm_frame_deser`

## Requirements
- R1: While `rstN` is low and after its release until the first frame start, `cmdValid`, `audioValid`, `idValid` and `chainOut` are 0, and `devId` is 0; no packet is decoded before the first frame start.
- R2: A frame starts at a bit clock edge where `frameSync` is sampled 1 after being sampled 0; the bit sampled at that edge is bit 31 of the command packet, and each following run of 32 bits forms the next packet, MSB first. A new frame start discards any partly received packet and restarts slot counting at the command slot.
- R3: While `idValid` is 0, `chainIn` sampled 1 at bit offset `t` of a frame (offset 0 is the frame-start bit) with `t < 2*MAX_DEV` sets `idValid` and `devId = t/2 + 1` (integer division) after that edge; once set, both hold until reset and later tokens are ignored.
- R4: `chainOut` repeats `chainIn` with two bit clocks of delay as seen by the next device: a token sampled at edge `k` is sampled by the next device at edge `k+2`.
- R5: The command packet is decoded with target ID in bits 31:27, extension flag in bit 26, register address in bits 23:16 and register data in bits 15:8; when `idValid` is 1 and the target ID equals `devId`, `cmdValid` pulses for one cycle right after the edge that samples bit 0, with `cmdAddr` and `cmdData` carrying the fields.
- R6: A command whose target ID differs from `devId`, or any command while `idValid` is 0, produces no `cmdValid` pulse.
- R7: When the command packet has bit 26 set, the packet after it is an extended command, decoded and qualified exactly as in R5 (its own bit 26 is ignored), and audio channel 1 moves to the packet after the extended one.
- R8: For each audio packet in an owned channel, `audioValid` pulses for one cycle right after the edge that samples its bit 0, `audioChan` gives the local index (0 for the lowest owned channel) and `audioData` carries packet bits 31:8; packet bits 7:0 have no effect on any output.
- R9: Audio packets in channels not owned by the device, including the unused slots at the end of a frame of 256 or 384 bit clocks, produce no `audioValid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| frameSync | input | 1 | Frame clock; its rising edge marks a frame start |
| sdIn | input | 1 | Serial data, MSB first per packet |
| chainIn | input | 1 | ID token from the previous device in the chain |
| chainOut | output | 1 | ID token passed to the next device |
| devId | output | 5 | Device ID taken from the token position |
| idValid | output | 1 | Device ID has been assigned |
| cmdValid | output | 1 | One-cycle strobe for a command addressed to this device |
| cmdAddr | output | 8 | Register address of the last accepted command |
| cmdData | output | 8 | Register data of the last accepted command |
| audioValid | output | 1 | One-cycle strobe for an owned audio sample |
| audioChan | output | 3 | Local index of the owned channel |
| audioData | output | 24 | Audio sample of the last owned channel packet |

## Verification
Command and audio strobes are due exactly one cycle after the edge that samples the last bit of their packet, ID assignment shows up one cycle after the edge that samples the token, and a token reaches the next device's sampling edge two clocks later. The bench's reference model advances on the same rising edge as the design and publishes its expected outputs for the cycle that follows, and every output is compared at the falling edge in between, so each result is checked in the very cycle it is due and not in a tolerance window. Per-frame pulse counts are read only after three idle bit clocks, once the last packet's strobe has certainly passed.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int PKT_W      = 32;
  localparam int SAMPLE_W   = 24;
  localparam int ID_W       = 5;
  localparam int ADDR_W     = 8;
  localparam int CDATA_W    = 8;
  localparam int CHAN_W     = 3;

  // Field positions inside a 32-bit command packet.
  localparam int CMD_ID_LSB   = 27;
  localparam int CMD_EXT_POS  = 26;
  localparam int CMD_ADDR_LSB = 16;
  localparam int CMD_DATA_LSB = 8;

  // Strobes handed from the control to the datapath on a packet boundary.
  typedef struct packed {
    logic              cmdLoad;
    logic              audioLoad;
    logic [CHAN_W-1:0] chanIdx;
  } tdmStrobe_t;
endpackage

// File: rtl/tdm_deser_ctrl.sv
module tdm_deser_ctrl
  import tdm_pkg::*;
#(
  parameter int OWN_CH  = 2,
  parameter int MAX_DEV = 30,
  parameter int SLOT_W  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameSync,
  input  logic            chainIn,
  input  logic [ID_W-1:0] hdrId,
  input  logic            hdrExt,
  output tdmStrobe_t      strobe,
  output logic            chainOut,
  output logic [ID_W-1:0] devId,
  output logic            idValid
);
  localparam int OFF_LIM = 2 * MAX_DEV;
  localparam int OFF_W   = $clog2(OFF_LIM + 1);
  localparam int BIT_W   = $clog2(PKT_W);
  localparam int NUM_W   = SLOT_W + ID_W + $clog2(OWN_CH + 1) + 1;

  logic              fsPrev;
  logic              inFrame;
  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [OFF_W-1:0]  offCnt;
  logic              extPend;
  logic [1:0]        chainDly;

  logic              frameStart;
  logic              lastBit;
  logic [OFF_W-1:0]  curOff;
  logic              idHit;
  logic              idMatch;
  logic              cmdSlot;
  logic [NUM_W-1:0]  chanNum;
  logic [NUM_W-1:0]  chanBase;
  logic [OWN_CH-1:0] chanHit;

  assign frameStart = frameSync & ~fsPrev;
  assign lastBit    = inFrame & ~frameStart & (bitCnt == BIT_W'(PKT_W - 1));
  assign curOff     = frameStart ? '0 : offCnt;
  assign idHit      = chainIn & (frameStart | inFrame) & ~idValid
                      & (curOff < OFF_W'(OFF_LIM));
  assign idMatch    = idValid & (hdrId == devId);
  assign cmdSlot    = (slotCnt == '0) | ((slotCnt == SLOT_W'(1)) & extPend);
  assign chainOut   = chainDly[1];

  // Channel numbering is 1-based and starts after the command packet(s).
  assign chanNum  = NUM_W'(slotCnt) - NUM_W'(extPend);
  assign chanBase = (NUM_W'(devId) - NUM_W'(1)) * NUM_W'(OWN_CH);

  for (genvar k = 0; k < OWN_CH; k++) begin : g_chan
    assign chanHit[k] = (chanNum == chanBase + NUM_W'(k + 1));
  end

  always_comb begin
    strobe         = '0;
    strobe.cmdLoad = lastBit & cmdSlot & idMatch;
    strobe.audioLoad = lastBit & ~cmdSlot & idValid & (|chanHit);
    for (int k = 0; k < OWN_CH; k++) begin
      if (chanHit[k]) strobe.chanIdx = CHAN_W'(k);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev   <= 1'b0;
      chainDly <= '0;
    end else begin
      fsPrev   <= frameSync;
      chainDly <= {chainDly[0], chainIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      bitCnt  <= '0;
      slotCnt <= '0;
      offCnt  <= '0;
      extPend <= 1'b0;
    end else if (frameStart) begin
      inFrame <= 1'b1;
      bitCnt  <= BIT_W'(1);
      slotCnt <= '0;
      offCnt  <= OFF_W'(1);
      extPend <= 1'b0;
    end else if (inFrame) begin
      bitCnt <= bitCnt + BIT_W'(1);
      if (lastBit) begin
        if (slotCnt != '1) slotCnt <= slotCnt + SLOT_W'(1);
        if (slotCnt == '0) extPend <= hdrExt;
      end
      if (offCnt != OFF_W'(OFF_LIM)) offCnt <= offCnt + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idValid <= 1'b0;
      devId   <= '0;
    end else if (idHit) begin
      idValid <= 1'b1;
      devId   <= ID_W'(curOff >> 1) + ID_W'(1);
    end
  end
endmodule

// File: rtl/tdm_deser_dp.sv
module tdm_deser_dp
  import tdm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdIn,
  input  tdmStrobe_t          strobe,
  output logic [ID_W-1:0]     hdrId,
  output logic                hdrExt,
  output logic                cmdValid,
  output logic [ADDR_W-1:0]   cmdAddr,
  output logic [CDATA_W-1:0]  cmdData,
  output logic                audioValid,
  output logic [CHAN_W-1:0]   audioChan,
  output logic [SAMPLE_W-1:0] audioData
);
  // The 31 earlier bits sit in shiftReg; packet bit n lives at shiftReg[n-1]
  // in the cycle its bit 0 is on sdIn.
  logic [PKT_W-2:0] shiftReg;

  assign hdrId  = shiftReg[CMD_ID_LSB-1 +: ID_W];
  assign hdrExt = shiftReg[CMD_EXT_POS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[PKT_W-3:0], sdIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid   <= 1'b0;
      cmdAddr    <= '0;
      cmdData    <= '0;
      audioValid <= 1'b0;
      audioChan  <= '0;
      audioData  <= '0;
    end else begin
      cmdValid   <= strobe.cmdLoad;
      audioValid <= strobe.audioLoad;
      if (strobe.cmdLoad) begin
        cmdAddr <= shiftReg[CMD_ADDR_LSB-1 +: ADDR_W];
        cmdData <= shiftReg[CMD_DATA_LSB-1 +: CDATA_W];
      end
      if (strobe.audioLoad) begin
        audioChan <= strobe.chanIdx;
        audioData <= shiftReg[PKT_W-2 -: SAMPLE_W];
      end
    end
  end
endmodule

// File: rtl/tdm_frame_deser.sv
module tdm_frame_deser
  import tdm_pkg::*;
#(
  parameter int OWN_CH  = 2,
  parameter int MAX_DEV = 30,
  parameter int SLOT_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameSync,
  input  logic                sdIn,
  input  logic                chainIn,
  output logic                chainOut,
  output logic [ID_W-1:0]     devId,
  output logic                idValid,
  output logic                cmdValid,
  output logic [ADDR_W-1:0]   cmdAddr,
  output logic [CDATA_W-1:0]  cmdData,
  output logic                audioValid,
  output logic [CHAN_W-1:0]   audioChan,
  output logic [SAMPLE_W-1:0] audioData
);
  tdmStrobe_t      strobe;
  logic [ID_W-1:0] hdrId;
  logic            hdrExt;

  tdm_deser_ctrl #(
    .OWN_CH (OWN_CH),
    .MAX_DEV(MAX_DEV),
    .SLOT_W (SLOT_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .frameSync(frameSync),
    .chainIn  (chainIn),
    .hdrId    (hdrId),
    .hdrExt   (hdrExt),
    .strobe   (strobe),
    .chainOut (chainOut),
    .devId    (devId),
    .idValid  (idValid)
  );

  tdm_deser_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .sdIn      (sdIn),
    .strobe    (strobe),
    .hdrId     (hdrId),
    .hdrExt    (hdrExt),
    .cmdValid  (cmdValid),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .audioValid(audioValid),
    .audioChan (audioChan),
    .audioData (audioData)
  );
endmodule

// File: rtl/tdm_deser_chk.sv
module tdm_deser_chk
  import tdm_pkg::*;
#(
  parameter int OWN_CH  = 2,
  parameter int MAX_DEV = 30
) (
  input logic              clk,
  input logic              rstN,
  input logic              chainIn,
  input logic              chainOut,
  input logic [ID_W-1:0]   devId,
  input logic              idValid,
  input logic              cmdValid,
  input logic              audioValid,
  input logic [CHAN_W-1:0] audioChan
);
  logic [1:0] rstAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rstAge <= '0;
    else if (rstAge != 2'd3) rstAge <= rstAge + 2'd1;
  end

  AST_CHAIN_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (rstAge >= 2'd2) |-> (chainOut == $past(chainIn, 2))); // R4
  AST_ID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(idValid) |-> (idValid && $stable(devId))); // R3
  AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    idValid |-> (devId >= ID_W'(1) && devId <= ID_W'(MAX_DEV))); // R3
  AST_CMD_NEEDS_ID: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> idValid); // R6
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R5
  AST_AUDIO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    audioValid |=> !audioValid); // R8
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && audioValid)); // R2
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    audioValid |-> (int'(audioChan) < OWN_CH)); // R8
  AST_AUDIO_NEEDS_ID: assert property (@(posedge clk) disable iff (!rstN)
    audioValid |-> idValid); // R9
endmodule

bind tdm_frame_deser tdm_deser_chk #(
  .OWN_CH (OWN_CH),
  .MAX_DEV(MAX_DEV)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .chainIn   (chainIn),
  .chainOut  (chainOut),
  .devId     (devId),
  .idValid   (idValid),
  .cmdValid  (cmdValid),
  .audioValid(audioValid),
  .audioChan (audioChan)
);

// File: tb/tdm_frame_deser_tb_top.sv
module tdm_frame_deser_tb_top;
  localparam int OWN = 2;
  localparam int MAXD = 30;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameSync = 1'b0;
  logic        sdIn = 1'b0;
  logic        chainIn = 1'b0;
  logic        chainOut;
  logic [4:0]  devId;
  logic        idValid;
  logic        cmdValid;
  logic [7:0]  cmdAddr;
  logic [7:0]  cmdData;
  logic        audioValid;
  logic [2:0]  audioChan;
  logic [23:0] audioData;

  always #4 clk = ~clk;

  tdm_frame_deser #(.OWN_CH(OWN), .MAX_DEV(MAXD), .SLOT_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .sdIn(sdIn),
    .chainIn(chainIn), .chainOut(chainOut), .devId(devId), .idValid(idValid),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .audioValid(audioValid), .audioChan(audioChan), .audioData(audioData)
  );

  int compared = 0;
  int mismatched = 0;
  bit started = 0;
  bit done = 0;
  int audCount = 0;
  int cmdCount = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mFsPrev, mInFrame, mExt, mIdv, mChainLast, mChainOut;
  int          mBits, mSlot, mOff, mId;
  logic [31:0] mAcc;
  bit          mCmdV, mAudV;
  int          mCmdAddr, mCmdData, mAudChan, mAudData;
  string       mCmdTag;

  always @(posedge clk) begin
    bit startNow, oldIdv;
    int oldId, c, base;
    logic [31:0] w;
    started = 1;
    if (!rstN) begin
      mFsPrev = 0; mInFrame = 0; mExt = 0; mIdv = 0; mChainLast = 0; mChainOut = 0;
      mBits = 0; mSlot = 0; mOff = 0; mId = 0; mAcc = 0;
      mCmdV = 0; mAudV = 0; mCmdAddr = 0; mCmdData = 0; mAudChan = 0; mAudData = 0;
      mCmdTag = "R1";
    end else begin
      mCmdV = 0; mAudV = 0; mCmdTag = "R6";
      startNow = frameSync && !mFsPrev;
      mFsPrev = frameSync;
      mChainOut = mChainLast;
      mChainLast = chainIn;
      if (startNow) begin
        mInFrame = 1; mBits = 0; mSlot = 0; mExt = 0; mOff = 0; mAcc = 0;
      end
      if (mInFrame) begin
        mAcc = {mAcc[30:0], sdIn};
        mBits++;
        oldIdv = mIdv; oldId = mId;
        if (mBits == 32) begin
          w = mAcc;
          if (mSlot == 0) begin
            mExt = w[26];
            if (oldIdv && int'(w[31:27]) == oldId) begin
              mCmdV = 1; mCmdAddr = int'(w[23:16]); mCmdData = int'(w[15:8]); mCmdTag = "R5";
            end
          end else if (mSlot == 1 && mExt) begin
            if (oldIdv && int'(w[31:27]) == oldId) begin
              mCmdV = 1; mCmdAddr = int'(w[23:16]); mCmdData = int'(w[15:8]); mCmdTag = "R7";
            end
          end else begin
            c = mSlot - int'(mExt);
            base = (oldId - 1) * OWN;
            if (oldIdv && c > base && c <= base + OWN) begin
              mAudV = 1; mAudChan = c - base - 1; mAudData = int'(w[31:8]);
            end
          end
          mSlot++; mBits = 0;
        end
        if (chainIn && !mIdv && mOff < 2 * MAXD) begin
          mId = mOff / 2 + 1; mIdv = 1;
        end
        mOff++;
      end
    end
  end

  // ---------------- comparison, away from the active edge ----------------
  always @(negedge clk) begin
    if (started && !done) begin
      chk(chainOut === mChainOut, rstN ? "R4" : "R1", "chainOut", chainOut, mChainOut);
      chk(idValid === mIdv && int'(devId) == mId, rstN ? "R3" : "R1", "idValid/devId",
          {idValid, devId}, {mIdv, 5'(mId)});
      chk(cmdValid === mCmdV, mCmdTag, "cmdValid", cmdValid, mCmdV);
      if (mCmdV) chk(int'(cmdAddr) == mCmdAddr && int'(cmdData) == mCmdData, mCmdTag,
                     "cmdAddr/cmdData", {cmdAddr, cmdData}, {8'(mCmdAddr), 8'(mCmdData)});
      chk(audioValid === mAudV, rstN ? "R8" : "R1", "audioValid", audioValid, mAudV);
      if (mAudV) chk(int'(audioChan) == mAudChan && int'(audioData) == mAudData, "R8",
                     "audioChan/audioData", {audioChan, audioData}, {3'(mAudChan), 24'(mAudData)});
      if (audioValid) audCount++;
      if (cmdValid) cmdCount++;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mkCmd(int id, bit ext, int addr, int data);
    return {5'(id), ext, 2'b00, 8'(addr), 8'(data), 8'hFF};
  endfunction

  function automatic logic [31:0] mkAud(int p, int f);
    return {8'(16 * f + p), 8'(8'hC3 ^ 8'(p)), 8'(7 * f + 3), 8'(8'h5A + 8'(p))};
  endfunction

  task automatic sendFrame(input int len, input int hi, input int chainOff,
                           input logic [31:0] cmdW, input logic [31:0] extW,
                           input bit useExt, input int fno);
    for (int b = 0; b < len; b++) begin
      logic [31:0] w;
      int p;
      p = b / 32;
      if (p == 0) w = cmdW;
      else if (p == 1 && useExt) w = extW;
      else w = mkAud(p, fno);
      @(negedge clk);
      frameSync = (b < hi);
      chainIn = (b == chainOff);
      sdIn = w[31 - (b % 32)];
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      frameSync = 1'b0; chainIn = 1'b0; sdIn = 1'b0;
    end
    @(posedge clk); #1;
  endtask

  task automatic countChk(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
    audCount = 0; cmdCount = 0;
  endtask

  initial begin
    rstN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(idValid === 1'b0 && cmdValid === 1'b0 && audioValid === 1'b0, "R1",
        "outputs after reset", {idValid, cmdValid, audioValid}, 0);

    // Frame 0: no token, command while unassigned must be ignored.
    sendFrame(256, 128, -1, mkCmd(0, 0, 8'h11, 8'h22), 0, 0, 0);
    chk(cmdCount == 0, "R6", "cmd pulses while unassigned", cmdCount, 0);
    countChk("R1", "audio pulses while unassigned", audCount, 0);

    // Frame A: token at odd offset 5 gives ID 3; command for ID 3 accepted.
    sendFrame(256, 128, 5, mkCmd(3, 0, 8'h40, 8'h9C), 0, 0, 1);
    chk(idValid === 1'b1 && devId == 5'd3, "R3", "assigned id", devId, 3);
    chk(cmdCount == 1, "R5", "cmd pulses frame A", cmdCount, 1);
    countChk("R8", "audio pulses frame A", audCount, 2);

    // Frame B: token at offset 0 must not change the ID.
    sendFrame(256, 128, 0, mkCmd(3, 0, 8'h41, 8'h3D), 0, 0, 2);
    chk(devId == 5'd3, "R3", "id after second token", devId, 3);
    chk(cmdCount == 1, "R5", "cmd pulses frame B", cmdCount, 1);
    countChk("R8", "audio pulses frame B", audCount, 2);

    // Frame C (384): command for another device with extension flag,
    // extended command for ID 3, audio shifted by one slot.
    sendFrame(384, 192, -1, mkCmd(2, 1, 8'h50, 8'h01), mkCmd(3, 1, 8'h77, 8'hE4), 1, 3);
    chk(cmdCount == 1, "R7", "cmd pulses frame C", cmdCount, 1);
    countChk("R7", "audio pulses frame C", audCount, 2);

    // Frame D (384): mismatching command, trailing slots not owned.
    sendFrame(384, 192, -1, mkCmd(4, 0, 8'h60, 8'h02), 0, 0, 4);
    chk(cmdCount == 0, "R6", "cmd pulses frame D", cmdCount, 0);
    countChk("R9", "audio pulses frame D", audCount, 2);

    // Frame E: cut short after 48 bits; frame F restarts cleanly.
    sendFrame(48, 24, -1, mkCmd(3, 0, 8'h70, 8'h05), 0, 0, 5);
    chk(cmdCount == 1, "R2", "cmd pulses short frame", cmdCount, 1);
    countChk("R2", "audio pulses short frame", audCount, 0);
    sendFrame(256, 128, -1, mkCmd(3, 0, 8'h71, 8'hA6), 0, 0, 6);
    chk(cmdCount == 1, "R2", "cmd pulses after restart", cmdCount, 1);
    countChk("R2", "audio pulses after restart", audCount, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule